// File: doc/BRIEF.md
# Double-Buffered Word-Bus Converter Code Register

This block is the digital front end of a 14-bit digital-to-analog converter that sits on a 14-bit parallel data bus. The incoming word is split into an upper byte (bits 13 to 8, six bits wide) and a lower byte (bits 7 to 0). Each byte has its own input register and its own active-low select. A single active-low write strobe qualifies every access. A separate active-low transfer strobe copies both input registers into the output code register, which drives the converter.

Because the transfer strobe is independent of the selects, several copies of the block can share one transfer line. Software fills each copy's input registers in turn. One access then makes every converter change code in the same clock cycle. Pulling both selects and the transfer strobe low together makes the block transparent: the bus word lands in the input registers and the code register on the same edge.

All strobes are sampled on the rising clock edge. The command decoder sorts each sample into one of eight named commands: IDLE, LOAD_UPPER, LOAD_LOWER, LOAD_BOTH, TRANSFER, LOAD_UPPER_TRANSFER, LOAD_LOWER_TRANSFER and PASS_THROUGH. The decoder keeps no history, so any command can follow any other. The registers step from their held values to the values the command selects.

Top module: `dac_dbuf_word`

## Requirements
- R1: An active-low reset clears both input registers and the output code to zero. A transfer issued right after reset therefore gives code 0.
- R2: With wr_n low, sel_up_n low, sel_lo_n high and xfer_n high, bus bits 13..8 are stored in the upper input register. The output code does not change.
- R3: With wr_n low, sel_up_n high, sel_lo_n low and xfer_n high, bus bits 7..0 are stored in the lower input register. The output code does not change.
- R4: With wr_n low, both selects low and xfer_n high, both input registers are loaded from the bus in one access. The output code does not change.
- R5: With wr_n low, both selects high and xfer_n low, the output code becomes {upper register, lower register} one cycle after the sampling edge.
- R6: With wr_n low and both selects and xfer_n all low, the bus word reaches the output code one cycle after the sampling edge. Both input registers also take the bus word.
- R7: With wr_n high, whatever the other strobes, or with both selects and xfer_n high, no register changes.
- R8: With wr_n low, xfer_n low and only one select low, the selected byte is loaded. The output code takes the new byte together with the other input register's held value.
- R9: When several blocks share wr_n, xfer_n and the bus, a transfer with all their selects high updates every output in the same cycle. Each output equals the word last loaded into that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 14 | Parallel data word, bit 13 most significant |
| sel_up_n | input | 1 | Active-low select of the upper input register (bits 13..8) |
| sel_lo_n | input | 1 | Active-low select of the lower input register (bits 7..0) |
| xfer_n | input | 1 | Active-low transfer strobe into the output code register |
| wr_n | input | 1 | Active-low write qualifier for every access |
| code_o | output | 14 | Code register contents driving the converter |

## Verification
The input registers cannot be seen directly at the ports. A wrong byte in one of them therefore stays hidden until the next transfer or a one-select transfer. It then shows up in exactly one half of code_o, one cycle after that transfer's sampling edge. A wrong decode shows up in the cycle after the faulty access:
- Output movement without a transfer shows as a changed code_o.
- A missed transfer shows as a stale code_o.

Four instances on shared strobes show whether a shared transfer moves every output in the same cycle.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    // Command classes decoded from one sample of the strobes.
    typedef enum logic [2:0] {
        CMD_IDLE        = 3'd0,
        CMD_LOAD_UP     = 3'd1,
        CMD_LOAD_LO     = 3'd2,
        CMD_LOAD_BOTH   = 3'd3,
        CMD_TRANSFER    = 3'd4,
        CMD_LOAD_UP_XF  = 3'd5,
        CMD_LOAD_LO_XF  = 3'd6,
        CMD_PASS        = 3'd7
    } dbuf_cmd_e;

    // Register enables derived from a command.
    typedef struct packed {
        logic up_we;
        logic lo_we;
        logic xfer;
    } dbuf_ctl_t;

endpackage

// File: rtl/dac_dbuf_decode.sv
module dac_dbuf_decode
    import dac_dbuf_pkg::*;
(
    input  logic      sel_up_n,
    input  logic      sel_lo_n,
    input  logic      xfer_n,
    input  logic      wr_n,
    output dbuf_cmd_e cmd,
    output dbuf_ctl_t ctl
);

    // Classify the strobe pattern.
    always_comb begin
        if (wr_n) begin
            cmd = CMD_IDLE;
        end else begin
            unique case ({sel_up_n, sel_lo_n, xfer_n})
                3'b011:  cmd = CMD_LOAD_UP;
                3'b101:  cmd = CMD_LOAD_LO;
                3'b001:  cmd = CMD_LOAD_BOTH;
                3'b110:  cmd = CMD_TRANSFER;
                3'b010:  cmd = CMD_LOAD_UP_XF;
                3'b100:  cmd = CMD_LOAD_LO_XF;
                3'b000:  cmd = CMD_PASS;
                default: cmd = CMD_IDLE;
            endcase
        end
    end

    // Turn the command into register enables.
    always_comb begin
        unique case (cmd)
            CMD_IDLE:       ctl = '{up_we: 1'b0, lo_we: 1'b0, xfer: 1'b0};
            CMD_LOAD_UP:    ctl = '{up_we: 1'b1, lo_we: 1'b0, xfer: 1'b0};
            CMD_LOAD_LO:    ctl = '{up_we: 1'b0, lo_we: 1'b1, xfer: 1'b0};
            CMD_LOAD_BOTH:  ctl = '{up_we: 1'b1, lo_we: 1'b1, xfer: 1'b0};
            CMD_TRANSFER:   ctl = '{up_we: 1'b0, lo_we: 1'b0, xfer: 1'b1};
            CMD_LOAD_UP_XF: ctl = '{up_we: 1'b1, lo_we: 1'b0, xfer: 1'b1};
            CMD_LOAD_LO_XF: ctl = '{up_we: 1'b0, lo_we: 1'b1, xfer: 1'b1};
            CMD_PASS:       ctl = '{up_we: 1'b1, lo_we: 1'b1, xfer: 1'b1};
            default:        ctl = '{up_we: 1'b0, lo_we: 1'b0, xfer: 1'b0};
        endcase
    end

endmodule

// File: rtl/dac_dbuf_hold_reg.sv
module dac_dbuf_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] nxt,
    output logic [W-1:0] q
);

    // Value the register holds after this edge, also forwarded for a transparent transfer.
    always_comb begin
        nxt = we ? d : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/dac_dbuf_word.sv
module dac_dbuf_word
    import dac_dbuf_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_i,
    input  logic              sel_up_n,
    input  logic              sel_lo_n,
    input  logic              xfer_n,
    input  logic              wr_n,
    output logic [DATA_W-1:0] code_o
);

    localparam int UP_W = DATA_W - LO_W;

    dbuf_cmd_e          cmd;
    dbuf_ctl_t          ctl;
    logic [UP_W-1:0]    up_q;
    logic [UP_W-1:0]    up_nxt;
    logic [LO_W-1:0]    lo_q;
    logic [LO_W-1:0]    lo_nxt;
    logic [DATA_W-1:0]  code_q;

    dac_dbuf_decode u_dec (
        .sel_up_n (sel_up_n),
        .sel_lo_n (sel_lo_n),
        .xfer_n   (xfer_n),
        .wr_n     (wr_n),
        .cmd      (cmd),
        .ctl      (ctl)
    );

    dac_dbuf_hold_reg #(.W(UP_W)) u_up (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.up_we),
        .d     (bus_i[DATA_W-1:LO_W]),
        .nxt   (up_nxt),
        .q     (up_q)
    );

    dac_dbuf_hold_reg #(.W(LO_W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.lo_we),
        .d     (bus_i[LO_W-1:0]),
        .nxt   (lo_nxt),
        .q     (lo_q)
    );

    // Output code register: a transfer takes the post-edge input values,
    // so a byte written in the same access passes straight through.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (ctl.xfer) begin
            code_q <= {up_nxt, lo_nxt};
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/dac_dbuf_word_chk.sv
module dac_dbuf_word_chk #(
    parameter int DATA_W = 14,
    parameter int LO_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_i,
    input logic              sel_up_n,
    input logic              sel_lo_n,
    input logic              xfer_n,
    input logic              wr_n,
    input logic [DATA_W-1:0] code_o,
    input logic [DATA_W-LO_W-1:0] up_q,
    input logic [LO_W-1:0]   lo_q
);

    // R1: the output is zero while reset is held.
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (code_o == '0)
                else $error("code not cleared in reset");
        end
    end

    a_r2_upper_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !sel_up_n) |=> up_q == $past(bus_i[DATA_W-1:LO_W]))
        else $error("upper input register missed a load");

    a_r3_lower_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !sel_lo_n) |=> lo_q == $past(bus_i[LO_W-1:0]))
        else $error("lower input register missed a load");

    a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !xfer_n && sel_up_n && sel_lo_n) |=> code_o == $past({up_q, lo_q}))
        else $error("transfer did not copy input registers");

    a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !xfer_n && !sel_up_n && !sel_lo_n) |=> code_o == $past(bus_i))
        else $error("transparent access did not pass the bus");

    a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n || xfer_n) |=> $stable(code_o))
        else $error("code moved without a transfer");

    a_r7_inputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n || (sel_up_n && sel_lo_n)) |=> ($stable(up_q) && $stable(lo_q)))
        else $error("input registers moved without a select");

    a_r8_upper_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !xfer_n && !sel_up_n && sel_lo_n)
            |=> code_o == {$past(bus_i[DATA_W-1:LO_W]), $past(lo_q)})
        else $error("upper load with transfer gave wrong code");

    a_r8_lower_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !xfer_n && sel_up_n && !sel_lo_n)
            |=> code_o == {$past(up_q), $past(bus_i[LO_W-1:0])})
        else $error("lower load with transfer gave wrong code");

endmodule

bind dac_dbuf_word dac_dbuf_word_chk #(.DATA_W(DATA_W), .LO_W(LO_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_i    (bus_i),
    .sel_up_n (sel_up_n),
    .sel_lo_n (sel_lo_n),
    .xfer_n   (xfer_n),
    .wr_n     (wr_n),
    .code_o   (code_o),
    .up_q     (up_q),
    .lo_q     (lo_q)
);

// File: tb/sim_dac_dbuf_word.sv
module sim_dac_dbuf_word;

    localparam int W  = 14;
    localparam int LW = 8;
    localparam int UW = W - LW;
    localparam int N  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0] bus = '0;
    logic wr_n = 1'b1;
    logic xfer_n = 1'b1;
    logic [N-1:0] sup_n = '1;
    logic [N-1:0] slo_n = '1;
    logic [W-1:0] code [N];

    logic [UW-1:0] m_up [N];
    logic [LW-1:0] m_lo [N];
    logic [W-1:0]  m_code [N];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    dac_dbuf_word u0 (.clk(clk), .rst_n(rst_n), .bus_i(bus), .sel_up_n(sup_n[0]),
        .sel_lo_n(slo_n[0]), .xfer_n(xfer_n), .wr_n(wr_n), .code_o(code[0]));
    dac_dbuf_word u1 (.clk(clk), .rst_n(rst_n), .bus_i(bus), .sel_up_n(sup_n[1]),
        .sel_lo_n(slo_n[1]), .xfer_n(xfer_n), .wr_n(wr_n), .code_o(code[1]));
    dac_dbuf_word u2 (.clk(clk), .rst_n(rst_n), .bus_i(bus), .sel_up_n(sup_n[2]),
        .sel_lo_n(slo_n[2]), .xfer_n(xfer_n), .wr_n(wr_n), .code_o(code[2]));
    dac_dbuf_word u3 (.clk(clk), .rst_n(rst_n), .bus_i(bus), .sel_up_n(sup_n[3]),
        .sel_lo_n(slo_n[3]), .xfer_n(xfer_n), .wr_n(wr_n), .code_o(code[3]));

    // Expected next upper byte for instance i, from R2/R4/R6/R8.
    function automatic logic [UW-1:0] exp_up(int i);
        return (!wr_n && !sup_n[i]) ? bus[W-1:LW] : m_up[i];
    endfunction

    // Expected next lower byte for instance i, from R3/R4/R6/R8.
    function automatic logic [LW-1:0] exp_lo(int i);
        return (!wr_n && !slo_n[i]) ? bus[LW-1:0] : m_lo[i];
    endfunction

    task automatic model_edge();
        for (int i = 0; i < N; i++) begin
            logic [UW-1:0] nu;
            logic [LW-1:0] nl;
            nu = exp_up(i);
            nl = exp_lo(i);
            if (!wr_n && !xfer_n) m_code[i] = {nu, nl};
            m_up[i] = nu;
            m_lo[i] = nl;
        end
    endtask

    task automatic chk(string tag, int idx, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst %0d: actual %h expected %h", tag, idx, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < N; i++) chk(tag, i, code[i], m_code[i]);
    endtask

    // Called just after a negedge with inputs set; returns at the next negedge.
    task automatic step();
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
    endtask

    task automatic drive(logic w, logic x, logic [N-1:0] su, logic [N-1:0] sl, logic [W-1:0] d);
        wr_n = w; xfer_n = x; sup_n = su; slo_n = sl; bus = d;
        step();
        wr_n = 1'b1; xfer_n = 1'b1; sup_n = '1; slo_n = '1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] words [N];
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            m_up[i] = '0; m_lo[i] = '0; m_code[i] = '0;
        end
        repeat (2) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b0, 1'b0, '1, '1, 14'h3FFF);
        check_all("R1 transfer after reset");

        // R2: upper byte only
        drive(1'b0, 1'b1, 4'b1110, 4'b1111, 14'h2A55);
        check_all("R2 no output change");
        drive(1'b0, 1'b0, '1, '1, 14'h0000);
        chk("R2 transfer", 0, code[0], 14'h2A00);

        // R3: lower byte only
        drive(1'b0, 1'b1, 4'b1111, 4'b1110, 14'h15C3);
        check_all("R3 no output change");
        drive(1'b0, 1'b0, '1, '1, 14'h0000);
        chk("R3 transfer", 0, code[0], 14'h2AC3);

        // R4: both bytes in one access
        drive(1'b0, 1'b1, 4'b1101, 4'b1101, 14'h1234);
        check_all("R4 no output change");
        drive(1'b0, 1'b0, '1, '1, 14'h3FFF);
        chk("R5 transfer", 1, code[1], 14'h1234);

        // R6: transparent, all instances
        drive(1'b0, 1'b0, '0, '0, 14'h3FFF);
        check_all("R6 full scale");
        drive(1'b0, 1'b0, '0, '0, 14'h0000);
        check_all("R6 zero");
        drive(1'b0, 1'b0, '1, '1, 14'h1111);
        check_all("R6 inputs took bus");

        // R7: write high, or nothing selected
        drive(1'b0, 1'b0, '0, '0, 14'h2001);
        drive(1'b1, 1'b0, '0, '0, 14'h1FFE);
        check_all("R7 write high");
        drive(1'b0, 1'b1, '1, '1, 14'h0F0F);
        drive(1'b0, 1'b0, '1, '1, 14'h0F0F);
        chk("R7 inputs kept", 2, code[2], 14'h2001);

        // R8: one select together with transfer
        drive(1'b0, 1'b0, 4'b1110, 4'b1111, 14'h3F00);
        chk("R8 upper with transfer", 0, code[0], 14'h3F01);
        drive(1'b0, 1'b0, 4'b1111, 4'b1110, 14'h00AA);
        chk("R8 lower with transfer", 0, code[0], 14'h3FAA);

        // R9: load four instances in turn, then one shared transfer
        for (int i = 0; i < N; i++) words[i] = W'($urandom);
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] s;
            s = '1;
            s[i] = 1'b0;
            drive(1'b0, 1'b1, s, '1, words[i]);
            drive(1'b0, 1'b1, '1, s, words[i]);
        end
        check_all("R9 before shared transfer");
        drive(1'b0, 1'b0, '1, '1, 14'h0000);
        for (int i = 0; i < N; i++) chk("R9 shared transfer", i, code[i], words[i]);

        // Random mix over all commands
        for (int k = 0; k < 600; k++) begin
            drive(1'($urandom_range(0, 3) == 0), 1'($urandom), 4'($urandom), 4'($urandom),
                  W'($urandom));
            check_all("random R2..R8");
        end

        finish_run();
    end

endmodule